// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register with Segmented Switch Decode

This block is the digital front end of a 16-bit voltage-output converter. A host writes a code word over a framed serial port: a low-active frame select, a serial clock and a data line. While the frame is open, each rising serial clock edge shifts one data bit, most significant bit first, into a shift register. When the frame closes after exactly sixteen bits, the word moves into the converter code register. The move happens at once if the update strobe is held low. If the strobe is high, the word is held pending until the strobe later falls.

All three port pins are brought into the system clock domain through two-flop synchronizers, and their edges are found there. The serial clock must therefore run well below half the system clock. The code register drives a segmented switch decoder. Its top four bits become fifteen equal-weight thermometer segment enables. Its low twelve bits drive the binary ladder switches directly. A frame that closes with any other bit count is thrown away, and it sets a sticky error flag.

Top module: `ser_dac_front`

## Requirements
- R1: During and after synchronous reset, `code_q`, `seg_en`, `ladder_sw` and `frame_err` are all zero. Code 0x0000 is the zero-output state.
- R2: While `frame_n` is low, each rising edge of `ser_clk` samples `ser_din`. The first bit sampled becomes bit 15 of the word. With `load_n` low, a rising edge of `frame_n` after exactly 16 bits places the word on `code_q`.
- R3: Toggling `ser_clk` while `frame_n` is high changes neither `code_q` nor `frame_err`.
- R4: When `frame_n` rises after a bit count other than 16 (0, 15 or 17, for example), `code_q` keeps its value and `frame_err` becomes 1. `frame_err` stays 1 until reset.
- R5: If `load_n` is high when a 16-bit frame closes, `code_q` keeps its old value. The next falling edge of `load_n` while `frame_n` is high loads the pending word.
- R6: A falling edge of `load_n` with no pending word leaves `code_q` unchanged. This includes a second pulse after a pending word has been consumed.
- R7: Bit k-1 of `seg_en` (k = 1..15) is 1 exactly when `code_q[15:12]` >= k. So value 0 gives all zeros and value 15 gives all ones.
- R8: `ladder_sw` equals `code_q[11:0]`.
- R9: Each falling edge of `frame_n` restarts the bit count. A correct 16-bit frame loads normally after a malformed one.
- R10: `seg_en` and `ladder_sw` follow `code_q` one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_din | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Low-active frame select |
| load_n | input | 1 | Low-active code update strobe, or tied low |
| code_q | output | 16 | Converter code register |
| seg_en | output | 15 | Thermometer segment enables, bit k-1 is segment k |
| ladder_sw | output | 12 | Binary ladder switch drives |
| frame_err | output | 1 | Sticky malformed-frame flag |

## Verification
Directed frames carry the codes 0x0000, 0x8000 and 0xFFFF plus single-bit patterns. These show bit order and the two extremes of the thermometer decoder. Strobe-held-low frames are set against deferred frames followed by one or two strobe pulses, which separates an immediate update from a pending one and catches a double consume. Frames of 0, 15 and 17 bits, idle serial clocks and a good frame after a bad one test the bit count. Seeded random frames mix all of these kinds against a bench model of the code register, its pending word and the error flag.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_NOW   = 2'd1,
    UPD_DEFER = 2'd2,
    UPD_DROP  = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= RST_VAL;
      q_prev <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      q_prev <= stage[DEPTH-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter
  import sdf_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_strobe,
  input  logic              frame_open,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              direct_mode,
  output upd_kind_e         kind,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (frame_start) begin
      cnt <= '0;
    end else if (frame_open && bit_strobe) begin
      sreg <= {sreg[WORD_W-2:0], bit_in};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    kind = UPD_NONE;
    if (frame_end) begin
      if (cnt != CNT_FULL)  kind = UPD_DROP;
      else if (direct_mode) kind = UPD_NOW;
      else                  kind = UPD_DEFER;
    end
  end

  assign word = sreg;
endmodule

// File: rtl/sdf_latch.sv
module sdf_latch
  import sdf_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_kind_e         kind,
  input  logic [WORD_W-1:0] word,
  input  logic              strobe_fall,
  output logic [WORD_W-1:0] code,
  output logic              err
);
  logic              pend;
  logic [WORD_W-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      pend      <= 1'b0;
      pend_word <= '0;
      err       <= 1'b0;
    end else begin
      unique case (kind)
        UPD_NOW: begin
          code <= word;
          pend <= 1'b0;
        end
        UPD_DEFER: begin
          pend_word <= word;
          pend      <= 1'b1;
        end
        UPD_DROP: err <= 1'b1;
        default: begin
          if (strobe_fall && pend) begin
            code <= pend_word;
            pend <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdf_decode.sv
module sdf_decode #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WORD_W-1:0]            code,
  output logic [(1<<SEG_BITS)-2:0]     seg_en,
  output logic [WORD_W-SEG_BITS-1:0]   ladder_sw
);
  localparam int unsigned SEG_N = (1 << SEG_BITS) - 1;
  localparam int unsigned LAD_W = WORD_W - SEG_BITS;

  logic [SEG_BITS-1:0] top;
  logic [SEG_N-1:0]    therm;

  assign top = code[WORD_W-1:LAD_W];

  for (genvar k = 1; k <= SEG_N; k++) begin : g_seg
    assign therm[k-1] = (top >= SEG_BITS'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_en    <= '0;
      ladder_sw <= '0;
    end else begin
      seg_en    <= therm;
      ladder_sw <= code[LAD_W-1:0];
    end
  end
endmodule

// File: rtl/ser_dac_front.sv
module ser_dac_front
  import sdf_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ser_clk,
  input  logic                        ser_din,
  input  logic                        frame_n,
  input  logic                        load_n,
  output logic [WORD_W-1:0]           code_q,
  output logic [(1<<SEG_BITS)-2:0]    seg_en,
  output logic [WORD_W-SEG_BITS-1:0]  ladder_sw,
  output logic                        frame_err
);
  localparam int unsigned PINS = 4;
  localparam logic [PINS-1:0] PIN_IDLE = 4'b1100;

  logic [PINS-1:0] pin_now, pin_prev;
  logic s_sck, s_din, s_frm, s_ld;
  logic p_sck, p_frm, p_ld;
  logic sck_rise, f_fall, f_rise, l_fall_hi;
  upd_kind_e kind;
  logic [WORD_W-1:0] word;

  sdf_sync #(.W(PINS), .DEPTH(SYNC_DEPTH), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst),
    .d({load_n, frame_n, ser_din, ser_clk}),
    .q(pin_now), .q_prev(pin_prev)
  );

  assign {s_ld, s_frm, s_din, s_sck} = pin_now;
  assign p_sck = pin_prev[0];
  assign p_frm = pin_prev[2];
  assign p_ld  = pin_prev[3];

  assign sck_rise  = s_sck & ~p_sck;
  assign f_fall    = ~s_frm & p_frm;
  assign f_rise    = s_frm & ~p_frm;
  assign l_fall_hi = ~s_ld & p_ld & s_frm & p_frm;

  sdf_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .bit_in(s_din), .bit_strobe(sck_rise),
    .frame_open(~s_frm), .frame_start(f_fall), .frame_end(f_rise),
    .direct_mode(~s_ld),
    .kind(kind), .word(word)
  );

  sdf_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst(rst),
    .kind(kind), .word(word), .strobe_fall(l_fall_hi),
    .code(code_q), .err(frame_err)
  );

  sdf_decode #(.WORD_W(WORD_W), .SEG_BITS(SEG_BITS)) u_dec (
    .clk(clk), .rst(rst),
    .code(code_q), .seg_en(seg_en), .ladder_sw(ladder_sw)
  );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEG_BITS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        f_rise,
  input logic                        l_fall_hi,
  input logic [WORD_W-1:0]           code_q,
  input logic [(1<<SEG_BITS)-2:0]    seg_en,
  input logic [WORD_W-SEG_BITS-1:0]  ladder_sw,
  input logic                        frame_err
);
  localparam int unsigned LAD_W = WORD_W - SEG_BITS;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (code_q == '0 && frame_err == 1'b0));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  p_code_source_r5: assert property (@(posedge clk) disable iff (rst)
    (code_q != $past(code_q)) |-> $past(f_rise || l_fall_hi));

  p_therm_shape_r7: assert property (@(posedge clk) disable iff (rst)
    ((seg_en & (seg_en + 1'b1)) == '0));

  p_therm_count_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(seg_en) == int'($past(code_q[WORD_W-1:LAD_W]))));

  p_ladder_r8: assert property (@(posedge clk) disable iff (rst)
    (ladder_sw == $past(code_q[LAD_W-1:0])));

  p_follow_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(code_q) |=> ($stable(seg_en) && $stable(ladder_sw)));
endmodule

bind ser_dac_front sdf_checker #(.WORD_W(WORD_W), .SEG_BITS(SEG_BITS)) u_chk (
  .clk(clk), .rst(rst), .f_rise(f_rise), .l_fall_hi(l_fall_hi),
  .code_q(code_q), .seg_en(seg_en), .ladder_sw(ladder_sw),
  .frame_err(frame_err)
);

// File: tb/test_ser_dac_front.sv
module test_ser_dac_front;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_din = 1'b0, frame_n = 1'b1, load_n = 1'b1;
  logic [15:0] code_q;
  logic [14:0] seg_en;
  logic [11:0] ladder_sw;
  logic frame_err;

  int n_chk = 0, n_err = 0;
  logic [15:0] m_code = '0, m_pend_word = '0;
  logic m_pend = 1'b0, m_err = 1'b0;

  always #2 clk = ~clk;

  ser_dac_front i_ser_dac_front (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .frame_n(frame_n), .load_n(load_n), .code_q(code_q),
    .seg_en(seg_en), .ladder_sw(ladder_sw), .frame_err(frame_err)
  );

  function automatic logic [14:0] exp_seg(input logic [15:0] c);
    logic [14:0] r;
    for (int k = 1; k <= 15; k++) r[k-1] = (int'(c[15:12]) >= k);
    return r;
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 code"}, 32'(code_q), 32'(m_code));
    chk({tag, " R7 seg"}, 32'(seg_en), 32'(exp_seg(m_code)));
    chk({tag, " R8 ladder"}, 32'(ladder_sw), 32'(m_code[11:0]));
    chk({tag, " R4 err"}, 32'(frame_err), 32'(m_err));
  endtask

  task automatic set_load(input logic v);
    if (load_n && !v && m_pend) begin
      m_code = m_pend_word;
      m_pend = 1'b0;
    end
    load_n = v;
    wait_cyc(8);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input logic direct);
    logic [15:0] got;
    got = '0;
    set_load(direct ? 1'b0 : 1'b1);
    frame_n = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? w[15-i] : 1'($urandom);
      got = {got[14:0], ser_din};
      ser_clk = 1'b0;
      wait_cyc(HALF);
      ser_clk = 1'b1;
      wait_cyc(HALF);
    end
    ser_clk = 1'b0;
    wait_cyc(HALF);
    frame_n = 1'b1;
    if (nbits != 16) m_err = 1'b1;
    else if (direct) begin
      m_code = got;
      m_pend = 1'b0;
    end else begin
      m_pend_word = got;
      m_pend = 1'b1;
    end
    wait_cyc(10);
  endtask

  task automatic pulse_load();
    set_load(1'b1);
    set_load(1'b0);
    set_load(1'b1);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      ser_din = 1'($urandom);
      ser_clk = 1'b1;
      wait_cyc(HALF);
      ser_clk = 1'b0;
      wait_cyc(HALF);
    end
    wait_cyc(6);
  endtask

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(5);
    check_all("R1 in reset");
    rst = 1'b0;
    wait_cyc(6);
    check_all("R1 after reset");

    pulse_load();
    check_all("R6 pulse with nothing pending");

    send(16'h8000, 16, 1'b1);
    check_all("R2 midscale direct");
    send(16'hFFFF, 16, 1'b1);
    check_all("R7 full scale direct");
    send(16'h0001, 16, 1'b1);
    check_all("R2 lsb only");

    send(16'hA5C3, 16, 1'b0);
    check_all("R5 deferred held");
    pulse_load();
    check_all("R5 deferred loaded");
    pulse_load();
    check_all("R6 second pulse");

    idle_clocks(20);
    check_all("R3 idle serial clocks");

    send(16'h1234, 15, 1'b1);
    check_all("R4 short frame");
    send(16'h4321, 17, 1'b1);
    check_all("R4 long frame");
    send(16'h0000, 0, 1'b1);
    check_all("R4 empty frame");
    send(16'h7FFE, 16, 1'b1);
    check_all("R9 good after bad");
    send(16'h0000, 16, 1'b1);
    check_all("R7 zero code");

    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = int'($urandom % 8);
      if (kind < 5) send(16'($urandom), 16, 1'($urandom));
      else if (kind == 5) send(16'($urandom), 1 + int'($urandom % 15), 1'($urandom));
      else if (kind == 6) pulse_load();
      else idle_clocks(3);
      check_all("R10 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule